// File: doc/BRIEF.md
# PMP Region Bounds Decoder

This block converts the configuration of one physical-memory-protection entry into an inclusive byte address range. It takes three inputs: the entry's two-bit matching mode, the entry's own address register and the address register of the entry just below it. From these it produces a start byte address, an end byte address and a flag that says whether the entry takes part in matching. A permission checker sits downstream and compares access addresses against these bounds. That checker can then work with plain inclusive ranges and does not need to decode the four matching modes itself.

Address registers hold byte addresses with the two least significant bits dropped. The byte bounds are therefore `REG_W + 2` bits wide. In naturally aligned power-of-two mode, the size of the region comes from a priority encoder that finds the first zero bit counting up from bit 0 of the register. The arithmetic uses one extra bit, so a region that reaches the top of the address space is formed without wrap-around. The decode is combinational. Parameter `REG_OUT` selects whether a register is placed on the outputs. The parameter `FIRST_ENTRY` marks the lowest entry: for that entry the lower neighbour's register is treated as zero.

Top module: `pmp_bounds_decoder`

## Requirements
- R1: The mode input is encoded 0 = off, 1 = top-of-range, 2 = four-byte aligned, 3 = power-of-two aligned. `region_active` is 1 exactly when the mode is not 0.
- R2: In off mode, `start_addr` is 0 and `end_addr` is all ones.
- R3: In top-of-range mode, `start_addr` is `{prev_addr, 2'b00}` and `end_addr` is `{cur_addr, 2'b00} - 1` modulo 2^(REG_W+2). If `cur_addr` is 0, `end_addr` therefore wraps to all ones.
- R4: When `FIRST_ENTRY` is 1, `prev_addr` is ignored and treated as zero, so in top-of-range mode `start_addr` is 0.
- R5: In four-byte mode, `start_addr` is `{cur_addr, 2'b00}` and `end_addr` is `start_addr + 3`. This also holds for the highest register value.
- R6: In power-of-two mode, let t be the count of consecutive one bits in `cur_addr` starting at bit 0, with t < REG_W. `start_addr` is `cur_addr` with bits [t-1:0] cleared, followed by two zero bits. `end_addr` is `start_addr + 2^(t+3) - 1`, and forming it never carries out of REG_W+2 bits.
- R7: In power-of-two mode, a `cur_addr` of all ones gives `start_addr` 0 and `end_addr` all ones.
- R8: In power-of-two mode, a `cur_addr` whose only zero bit is its most significant bit (t = REG_W-1) also covers the whole space: `start_addr` is 0 and `end_addr` is all ones.
- R9: With `REG_OUT` = 1, the outputs reflect the inputs of the previous rising clock edge. A synchronous active-high `rst` sets `region_active` to 0, `start_addr` to 0 and `end_addr` to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Matching mode of this entry |
| cur_addr | input | REG_W | This entry's address register (byte address >> 2) |
| prev_addr | input | REG_W | Lower neighbour's address register |
| start_addr | output | REG_W+2 | Inclusive first byte of the region |
| end_addr | output | REG_W+2 | Inclusive last byte of the region |
| region_active | output | 1 | Entry participates in matching |

## Verification
Any error inside the block shows on the ports one clock after the inputs that expose it, because only the output register lies between the decode and the pins. Suppose the trailing-ones encoder picks the wrong bit. Then power-of-two regions come out with a misaligned start or an end that is off by a power of two, and the all-ones and top-bit-zero registers show this most clearly. A wrong mode decode or a wrong neighbour selection swaps whole range formulas. Top-of-range and four-byte checks with edge addresses then show it at once.

// File: rtl/pmpdec_pkg.sv
package pmpdec_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } pmp_mode_e;
endpackage

// File: rtl/pmpdec_tones.sv
// Priority encoder: index of the lowest zero bit, i.e. the trailing-ones count.
module pmpdec_tones #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count,
  output logic          full
);
  always_comb begin
    count = CW'(W);
    full  = 1'b1;
    for (int i = W - 1; i >= 0; i--) begin
      if (!vec[i]) begin
        count = CW'(i);
        full  = 1'b0;
      end
    end
    // R6: the reported boundary bit must be a zero
    if (!full) begin
      assert_zero_at_count_R6: assert (vec[count] == 1'b0);
    end
  end
endmodule

// File: rtl/pmpdec_napot.sv
// Power-of-two region bounds from the trailing-ones count.
module pmpdec_napot #(
  parameter int REG_W = 32,
  parameter int CW    = $clog2(REG_W + 1),
  parameter int BA_W  = REG_W + 2
) (
  input  logic [REG_W-1:0] cur,
  input  logic [CW-1:0]    count,
  input  logic             full,
  output logic [BA_W-1:0]  lo,
  output logic [BA_W-1:0]  hi
);
  logic [REG_W:0]  low_mask;
  logic [BA_W-1:0] base;
  logic [BA_W:0]   span;
  logic [BA_W:0]   sum;

  always_comb begin
    low_mask = ((REG_W + 1)'(1) << count) - (REG_W + 1)'(1);
    base     = {cur & ~low_mask[REG_W-1:0], 2'b00};
    span     = ((BA_W + 1)'(1) << (int'(count) + 3)) - (BA_W + 1)'(1);
    sum      = {1'b0, base} + span;
    if (full) begin
      lo = '0;
      hi = '1;
    end else begin
      lo = base;
      hi = sum[BA_W-1:0];
      assert_no_overflow_R6: assert (sum[BA_W] == 1'b0);
    end
  end
endmodule

// File: rtl/pmp_bounds_decoder.sv
module pmp_bounds_decoder #(
  parameter int REG_W       = 32,
  parameter bit REG_OUT     = 1'b1,
  parameter bit FIRST_ENTRY = 1'b0,
  localparam int BA_W       = REG_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [REG_W-1:0] cur_addr,
  input  logic [REG_W-1:0] prev_addr,
  output logic [BA_W-1:0]  start_addr,
  output logic [BA_W-1:0]  end_addr,
  output logic             region_active
);
  import pmpdec_pkg::*;
  localparam int CW = $clog2(REG_W + 1);

  pmp_mode_e        mode_e;
  logic [REG_W-1:0] prev_eff;
  logic [CW-1:0]    ones_cnt;
  logic             ones_full;
  logic [BA_W-1:0]  np_lo, np_hi;
  logic [BA_W-1:0]  lo_c, hi_c;
  logic             act_c;

  assign mode_e = pmp_mode_e'(mode);

  generate
    if (FIRST_ENTRY) begin : g_first
      assign prev_eff = '0;
    end else begin : g_mid
      assign prev_eff = prev_addr;
    end
  endgenerate

  pmpdec_tones #(.W(REG_W), .CW(CW)) tones_i (
    .vec(cur_addr), .count(ones_cnt), .full(ones_full)
  );

  pmpdec_napot #(.REG_W(REG_W), .CW(CW), .BA_W(BA_W)) napot_i (
    .cur(cur_addr), .count(ones_cnt), .full(ones_full), .lo(np_lo), .hi(np_hi)
  );

  always_comb begin
    act_c = 1'b1;
    unique case (mode_e)
      MODE_TOR: begin
        lo_c = {prev_eff, 2'b00};
        hi_c = {cur_addr, 2'b00} - BA_W'(1);
      end
      MODE_NA4: begin
        lo_c = {cur_addr, 2'b00};
        hi_c = {cur_addr, 2'b11};
      end
      MODE_NAPOT: begin
        lo_c = np_lo;
        hi_c = np_hi;
      end
      default: begin
        lo_c  = '0;
        hi_c  = '1;
        act_c = 1'b0;
      end
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          start_addr    <= '0;
          end_addr      <= '1;
          region_active <= 1'b0;
        end else begin
          start_addr    <= lo_c;
          end_addr      <= hi_c;
          region_active <= act_c;
        end
      end

      assert_active_R1: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0) |=> region_active);
      assert_off_whole_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |=> (!region_active && start_addr == '0 && end_addr == '1));
      assert_tor_base_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> (start_addr == {$past(prev_eff), 2'b00}));
      assert_na4_span_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |=> (BA_W'(end_addr - start_addr) == BA_W'(3)));
      assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!region_active && start_addr == '0 && end_addr == '1));
    end else begin : g_comb
      assign start_addr    = lo_c;
      assign end_addr      = hi_c;
      assign region_active = act_c;
    end
  endgenerate
endmodule

// File: tb/pmp_bounds_decoder_tb_top.sv
module pmp_bounds_decoder_tb_top;
  localparam int REG_W = 32;
  localparam int BA_W  = REG_W + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       mode = 2'd0;
  logic [REG_W-1:0] cur_addr = '0;
  logic [REG_W-1:0] prev_addr = '0;
  logic [BA_W-1:0]  s_mid, e_mid, s_fst, e_fst;
  logic             a_mid, a_fst;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  pmp_bounds_decoder #(.REG_W(REG_W), .REG_OUT(1'b1), .FIRST_ENTRY(1'b0)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .cur_addr(cur_addr), .prev_addr(prev_addr),
    .start_addr(s_mid), .end_addr(e_mid), .region_active(a_mid)
  );

  pmp_bounds_decoder #(.REG_W(REG_W), .REG_OUT(1'b1), .FIRST_ENTRY(1'b1)) dut0_i (
    .clk(clk), .rst(rst), .mode(mode), .cur_addr(cur_addr), .prev_addr(prev_addr),
    .start_addr(s_fst), .end_addr(e_fst), .region_active(a_fst)
  );

  function automatic void model(input logic [1:0] m, input logic [REG_W-1:0] c,
                                input logic [REG_W-1:0] p, input bit first,
                                output logic [BA_W-1:0] s, output logic [BA_W-1:0] e,
                                output logic v);
    logic [BA_W:0] big;
    int t;
    v = (m != 2'd0);
    case (m)
      2'd1: begin
        s = first ? '0 : {p, 2'b00};
        e = {c, 2'b00} - BA_W'(1);
      end
      2'd2: begin
        s = {c, 2'b00};
        e = s + BA_W'(3);
      end
      2'd3: begin
        t = 0;
        while (t < REG_W && c[t]) t++;
        if (t == REG_W) begin
          s = '0; e = '1;
        end else begin
          s = {(c >> t) << t, 2'b00};
          big = {1'b0, s} + ((BA_W + 1)'(1) << (t + 3)) - (BA_W + 1)'(1);
          e = big[BA_W-1:0];
        end
      end
      default: begin
        s = '0; e = '1;
      end
    endcase
  endfunction

  task automatic cmp(input string req, input logic [BA_W-1:0] s, input logic [BA_W-1:0] e,
                     input logic v, input logic [BA_W-1:0] xs, input logic [BA_W-1:0] xe,
                     input logic xv);
    vectors++;
    if (s !== xs || e !== xe || v !== xv) begin
      errors++;
      $display("FAIL %s: got start=%h end=%h act=%b, expected start=%h end=%h act=%b",
               req, s, e, v, xs, xe, xv);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] m,
                       input logic [REG_W-1:0] c, input logic [REG_W-1:0] p);
    logic [BA_W-1:0] xs, xe;
    logic xv;
    @(negedge clk);
    mode = m; cur_addr = c; prev_addr = p;
    @(negedge clk);
    model(m, c, p, 1'b0, xs, xe, xv);
    cmp(req, s_mid, e_mid, a_mid, xs, xe, xv);
    model(m, c, p, 1'b1, xs, xe, xv);
    cmp({req, "/R4"}, s_fst, e_fst, a_fst, xs, xe, xv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("R9 reset", s_mid, e_mid, a_mid, '0, '1, 1'b0);
    cmp("R9 reset", s_fst, e_fst, a_fst, '0, '1, 1'b0);
    rst = 1'b0;

    apply("R1 R2 off", 2'd0, 32'h1234_5678, 32'h0000_0100);
    apply("R3 tor", 2'd1, 32'h0000_0400, 32'h0000_0100);
    apply("R3 tor wrap", 2'd1, 32'h0, 32'h0000_0010);
    apply("R4 tor first", 2'd1, 32'h8000_0000, 32'hFFFF_FFFF);
    apply("R5 na4", 2'd2, 32'h0000_0003, 32'h0);
    apply("R5 na4 top", 2'd2, 32'hFFFF_FFFF, 32'h0);
    apply("R6 napot t0", 2'd3, 32'h2000_0000, 32'h0);
    apply("R6 napot t5", 2'd3, 32'h2000_001F, 32'h0);
    apply("R7 napot all", 2'd3, 32'hFFFF_FFFF, 32'h0);
    apply("R8 napot top", 2'd3, 32'h7FFF_FFFF, 32'h0);
    apply("R6 napot t30", 2'd3, 32'hBFFF_FFFF, 32'h0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      logic [REG_W-1:0] c;
      int k;
      m = 2'($urandom_range(0, 3));
      c = $urandom;
      if (m == 2'd3) begin
        k = $urandom_range(0, REG_W - 1);
        c = ((c << (k + 1)) | ((32'h1 << k) - 32'h1));
        apply("R6 napot rand", m, c, $urandom);
      end else if (m == 2'd1) apply("R3 tor rand", m, c, $urandom);
      else if (m == 2'd2) apply("R5 na4 rand", m, c, $urandom);
      else apply("R2 off rand", m, c, $urandom);
    end

    // R9: reset mid-run returns to idle values
    @(negedge clk);
    mode = 2'd3; cur_addr = 32'h5; rst = 1'b1;
    @(negedge clk);
    cmp("R9 reset again", s_mid, e_mid, a_mid, '0, '1, 1'b0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule